// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Engine

This block moves bytes over a two-wire synchronous link. One line is bidirectional and carries the data. The other is an output that drives the shift clock. The engine works only when the two-bit mode select is zero. A one-cycle write strobe with a byte starts a transmit. While the engine is idle, with the receive enable high and the receive-done flag clear, it starts a receive instead. In both directions it drives eight clock pulses and moves eight bits, least significant bit first. Each bit lasts a fixed number of core clocks, which by default is twelve.

During a bit period the shift clock is low for the first part and high for the second part. Transmit data changes only at the start of a period, while the clock is low. Receive data is sampled on the core-clock edge where the shift clock rises. The data line is driven only during a transmit and is released at all other times. When a transmit ends, the transmit-done flag is set. When a receive ends, the received byte is loaded into a buffer and the receive-done flag is set. Each flag stays set until its clear input is pulsed. A new receive is not armed while the receive-done flag is set.

Top module: `ssr_engine`

## Requirements
- R1: After reset the shift clock is high, the data output enable is low, both done flags are 0 and the receive buffer is 0.
- R2: With mode select 2'b00 and the engine idle, a write strobe starts a transmit. The data output enable is high for 96 clocks, and the data line carries bit k of the byte during clocks 12k to 12k+11 after the strobe edge (k = 0 first, so the least significant bit goes first).
- R3: In every 12-clock bit period the shift clock is low for clocks 0 to 5 and high for clocks 6 to 11. There are exactly eight low pulses per transfer, and the clock rests high while idle.
- R4: The transmit-done flag rises 96 clocks after the strobe edge and stays set until clr_tx_done is high at a clock edge.
- R5: With mode select 2'b00, the engine idle, rx_en high and the receive-done flag 0, a receive starts. The data output enable stays low for the whole receive.
- R6: A receive samples sdata_in at the edge where the shift clock rises, bit 0 first. After 96 clocks it loads rx_buf with the eight sampled bits and sets the receive-done flag.
- R7: While the receive-done flag is set, rx_en held high starts no new receive: the shift clock stays high.
- R8: A write strobe during a transfer is ignored. The transfer in progress completes with its original byte.
- R9: With mode select other than 2'b00, neither a write strobe nor rx_en starts a transfer.
- R10: A clear input drops its flag at the next edge. When the flag is being set in the same cycle as its clear, the set takes effect.
- R11: When a write strobe and a valid receive arm occur in the same idle cycle, the transmit starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode select; engine active only at 2'b00 |
| wr_stb | input | 1 | Write strobe that starts a transmit |
| wr_byte | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_done | input | 1 | Clears the receive-done flag |
| sdata_in | input | 1 | Data line input value |
| sdata_out | output | 1 | Data line output value |
| sdata_oe | output | 1 | Data line output enable |
| sclk_out | output | 1 | Shift clock output |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| rx_buf | output | 8 | Received byte buffer |

## Verification
A phase counter that is off by one moves the shift-clock edges away from clock 6 of the period. It also moves the done flags away from clock 96. The bench compares every cycle of every transfer against a computed pattern, so such a fault shows within the first bit period. A fault in the shift register or the bit counter corrupts a data bit or the number of pulses. A transmit shows this on the line in the bit where it occurs. A receive shows it in rx_buf at clock 96. A fault in the arming logic shows as clock pulses while the engine should be idle, within one cycle of the stimulus.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    SSR_IDLE = 2'd0,
    SSR_TX   = 2'd1,
    SSR_RX   = 2'd2
  } ssr_state_e;

  // Shift clock is low during the leading part of the bit period.
  function automatic logic phase_is_low(input int unsigned phase,
                                        input int unsigned low_clks);
    return (phase < low_clks);
  endfunction

  // Clocks from the start edge to the done flag.
  function automatic int unsigned frame_clocks(input int unsigned per_bit,
                                               input int unsigned nbits);
    return per_bit * nbits;
  endfunction

endpackage

// File: rtl/ssr_timer.sv
module ssr_timer #(
  parameter int unsigned CLKS_PER_BIT = 12,
  parameter int unsigned LOW_CLKS     = 6,
  parameter int unsigned NBITS        = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic ev_sample,
  output logic ev_bit_end,
  output logic ev_last,
  output logic sclk_low
);
  import ssr_pkg::*;

  localparam int unsigned PW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int unsigned BW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [PW-1:0] PH_LAST   = PW'(CLKS_PER_BIT - 1);
  localparam logic [PW-1:0] PH_SAMPLE = PW'(LOW_CLKS - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(NBITS - 1);

  logic [PW-1:0] phase;
  logic [BW-1:0] bitidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      bitidx <= '0;
    end else if (start) begin
      phase  <= '0;
      bitidx <= '0;
    end else if (run) begin
      if (phase == PH_LAST) begin
        phase  <= '0;
        bitidx <= bitidx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign ev_sample  = run && (phase == PH_SAMPLE);
  assign ev_bit_end = run && (phase == PH_LAST);
  assign ev_last    = ev_bit_end && (bitidx == BIT_LAST);
  assign sclk_low   = run && phase_is_low(int'(phase), LOW_CLKS);

endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
  parameter int unsigned NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NBITS-1:0] load_val,
  input  logic             shift_tx,
  input  logic             shift_rx,
  input  logic             rx_bit,
  output logic [NBITS-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (load)     q <= load_val;
    else if (shift_rx) q <= {rx_bit, q[NBITS-1:1]};
    else if (shift_tx) q <= {1'b1, q[NBITS-1:1]};
  end

endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl #(
  parameter int unsigned NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             wr_stb,
  input  logic             rx_en,
  input  logic             clr_tx_done,
  input  logic             clr_rx_done,
  input  logic             ev_last,
  input  logic [NBITS-1:0] shreg,
  output logic             start_tx,
  output logic             start_rx,
  output logic             tx_active,
  output logic             rx_active,
  output logic             tx_done,
  output logic             rx_done,
  output logic [NBITS-1:0] rx_buf
);
  import ssr_pkg::*;

  ssr_state_e state;
  logic idle, mode_ok;

  assign idle      = (state == SSR_IDLE);
  assign mode_ok   = (mode_sel == 2'b00);
  assign start_tx  = idle && mode_ok && wr_stb;
  assign start_rx  = idle && mode_ok && rx_en && !rx_done && !wr_stb;
  assign tx_active = (state == SSR_TX);
  assign rx_active = (state == SSR_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SSR_IDLE;
    end else begin
      unique case (state)
        SSR_IDLE: begin
          if (start_tx)      state <= SSR_TX;
          else if (start_rx) state <= SSR_RX;
        end
        SSR_TX, SSR_RX: begin
          if (ev_last) state <= SSR_IDLE;
        end
        default: state <= SSR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      rx_buf  <= '0;
    end else begin
      if (ev_last && tx_active) tx_done <= 1'b1;
      else if (clr_tx_done)     tx_done <= 1'b0;
      if (ev_last && rx_active) begin
        rx_done <= 1'b1;
        rx_buf  <= shreg;
      end else if (clr_rx_done) begin
        rx_done <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ssr_engine.sv
module ssr_engine #(
  parameter int unsigned CLKS_PER_BIT = 12,
  parameter int unsigned LOW_CLKS     = 6,
  parameter int unsigned DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_sel,
  input  logic                 wr_stb,
  input  logic [DATA_BITS-1:0] wr_byte,
  input  logic                 rx_en,
  input  logic                 clr_tx_done,
  input  logic                 clr_rx_done,
  input  logic                 sdata_in,
  output logic                 sdata_out,
  output logic                 sdata_oe,
  output logic                 sclk_out,
  output logic                 tx_done,
  output logic                 rx_done,
  output logic [DATA_BITS-1:0] rx_buf
);

  logic start_tx, start_rx, start_any;
  logic tx_active, rx_active, busy;
  logic ev_sample, ev_bit_end, ev_last, sclk_low;
  logic [DATA_BITS-1:0] shreg;

  assign start_any = start_tx || start_rx;
  assign busy      = tx_active || rx_active;

  ssr_timer #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .LOW_CLKS    (LOW_CLKS),
    .NBITS       (DATA_BITS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_any),
    .run       (busy),
    .ev_sample (ev_sample),
    .ev_bit_end(ev_bit_end),
    .ev_last   (ev_last),
    .sclk_low  (sclk_low)
  );

  ssr_shifter #(.NBITS(DATA_BITS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_any),
    .load_val(start_tx ? wr_byte : '0),
    .shift_tx(tx_active && ev_bit_end && !ev_last),
    .shift_rx(rx_active && ev_sample),
    .rx_bit  (sdata_in),
    .q       (shreg)
  );

  ssr_ctrl #(.NBITS(DATA_BITS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .wr_stb     (wr_stb),
    .rx_en      (rx_en),
    .clr_tx_done(clr_tx_done),
    .clr_rx_done(clr_rx_done),
    .ev_last    (ev_last),
    .shreg      (shreg),
    .start_tx   (start_tx),
    .start_rx   (start_rx),
    .tx_active  (tx_active),
    .rx_active  (rx_active),
    .tx_done    (tx_done),
    .rx_done    (rx_done),
    .rx_buf     (rx_buf)
  );

  assign sdata_oe  = tx_active;
  assign sdata_out = tx_active ? shreg[0] : 1'b1;
  assign sclk_out  = !sclk_low;

endmodule

// File: rtl/ssr_engine_chk.sv
module ssr_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       wr_stb,
  input logic       clr_tx_done,
  input logic       sdata_out,
  input logic       sdata_oe,
  input logic       sclk_out,
  input logic       tx_done,
  input logic       rx_done,
  input logic       tx_active,
  input logic       rx_active,
  input logic       ev_sample,
  input logic       ev_bit_end
);

  a_r2_tx_drives_line: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> sdata_oe);

  a_r2_data_holds_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !ev_bit_end) |=> $stable(sdata_out));

  a_r3_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_active || rx_active) |-> sclk_out);

  a_r6_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample |-> (!sclk_out ##1 sclk_out));

  a_r4_tx_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !clr_tx_done) |=> tx_done);

  a_r5_rx_released: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> !sdata_oe);

  a_r7_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !tx_active && !rx_active && !wr_stb) |=> !rx_active);

  a_r9_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !rx_active && mode_sel != 2'b00) |=> !(tx_active || rx_active));

  a_r11_tx_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !rx_active && mode_sel == 2'b00 && wr_stb) |=> tx_active);

endmodule

bind ssr_engine ssr_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .wr_stb     (wr_stb),
  .clr_tx_done(clr_tx_done),
  .sdata_out  (sdata_out),
  .sdata_oe   (sdata_oe),
  .sclk_out   (sclk_out),
  .tx_done    (tx_done),
  .rx_done    (rx_done),
  .tx_active  (tx_active),
  .rx_active  (rx_active),
  .ev_sample  (ev_sample),
  .ev_bit_end (ev_bit_end)
);

// File: tb/tb_ssr_engine.sv
`timescale 1ns/1ps
module tb_ssr_engine;

  localparam int PER  = 12;
  localparam int LOWC = 6;
  localparam int NB   = 8;
  localparam int FRAME = PER * NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic wr_stb = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic rx_en = 1'b0;
  logic clr_tx_done = 1'b0;
  logic clr_rx_done = 1'b0;
  logic sdata_in = 1'b1;
  logic sdata_out, sdata_oe, sclk_out, tx_done, rx_done;
  logic [7:0] rx_buf;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ssr_engine dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .rx_en(rx_en), .clr_tx_done(clr_tx_done),
    .clr_rx_done(clr_rx_done), .sdata_in(sdata_in), .sdata_out(sdata_out),
    .sdata_oe(sdata_oe), .sclk_out(sclk_out), .tx_done(tx_done),
    .rx_done(rx_done), .rx_buf(rx_buf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic clk_expect(input int c);
    return (c % PER) >= LOWC;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected < 190000 cycles", cyc);
      finish_run();
    end
  end

  task automatic clear_flags();
    @(negedge clk); clr_tx_done = 1; clr_rx_done = 1;
    @(negedge clk); clr_tx_done = 0; clr_rx_done = 0;
  endtask

  // Transmit; optionally inject a busy write and/or hold clear across the end.
  task automatic do_tx(input logic [7:0] b, input bit inject, input bit hold_clr);
    bit wave_ok = 1;
    logic [31:0] wact = 0, wexp = 0;
    @(negedge clk); wr_stb = 1; wr_byte = b; clr_tx_done = hold_clr;
    @(negedge clk); wr_stb = 0;
    for (int c = 0; c < FRAME; c++) begin
      if (c > 0) @(negedge clk);
      if (inject && c == 30) begin wr_stb = 1; wr_byte = ~b; end
      if (inject && c == 31) wr_stb = 0;
      if (wave_ok && (sclk_out !== clk_expect(c) || sdata_oe !== 1'b1 ||
                      sdata_out !== b[c / PER] || tx_done !== 1'b0)) begin
        wave_ok = 0;
        wact = {c[15:0], 4'(sclk_out), 4'(sdata_oe), 4'(sdata_out), 4'(tx_done)};
        wexp = {c[15:0], 4'(clk_expect(c)), 4'h1, 4'(b[c / PER]), 4'h0};
      end
    end
    @(negedge clk);
    chk(inject ? "R8 busy write ignored" : "R2/R3 tx waveform", wact, wexp);
    chk(hold_clr ? "R10 set beats clear" : "R4 tx_done at 96", {tx_done, sdata_oe, sclk_out}, 3'b101);
    clr_tx_done = 0;
  endtask

  task automatic do_rx(input logic [7:0] b, input bit hold_after);
    bit wave_ok = 1;
    logic [31:0] wact = 0, wexp = 0;
    @(negedge clk); rx_en = 1;
    @(negedge clk);
    for (int c = 0; c < FRAME; c++) begin
      if (c > 0) @(negedge clk);
      sdata_in = b[c / PER];
      if (wave_ok && (sclk_out !== clk_expect(c) || sdata_oe !== 1'b0 || rx_done !== 1'b0)) begin
        wave_ok = 0;
        wact = {c[15:0], 4'(sclk_out), 4'(sdata_oe), 4'(rx_done)};
        wexp = {c[15:0], 4'(clk_expect(c)), 4'h0, 4'h0};
      end
    end
    @(negedge clk);
    chk("R5/R3 rx waveform", wact, wexp);
    chk("R6 rx_buf", {rx_done, rx_buf}, {1'b1, b});
    sdata_in = ~sdata_in;
    if (hold_after) begin
      bit quiet = 1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (sclk_out !== 1'b1) quiet = 0;
      end
      chk("R7 no rearm while rx_done", {quiet, rx_buf}, {1'b1, b});
    end
    rx_en = 0;
    clear_flags();
    chk("R10 rx_done cleared", rx_done, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {sclk_out, sdata_oe, tx_done, rx_done, rx_buf}, {4'b1000, 8'h00});
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {sclk_out, sdata_oe, tx_done, rx_done}, 4'b1000);

    for (int v = 0; v < 256; v++) begin
      do_tx(8'(v), 0, 0);
      clear_flags();
      chk("R10 tx_done cleared", tx_done, 1'b0);
    end
    do_tx(8'hA5, 1, 0);
    clear_flags();
    do_tx(8'h3C, 0, 1);
    clear_flags();

    for (int v = 0; v < 256; v++) do_rx(8'(v), v == 8'h96);

    // R9: other modes start nothing
    for (int m = 1; m < 4; m++) begin
      bit quiet = 1;
      mode_sel = 2'(m);
      @(negedge clk); wr_stb = 1; wr_byte = 8'h55; rx_en = 1;
      @(negedge clk); wr_stb = 0;
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (sclk_out !== 1'b1 || sdata_oe !== 1'b0) quiet = 0;
      end
      rx_en = 0;
      chk("R9 mode gate", {quiet, tx_done, rx_done}, 3'b100);
    end
    mode_sel = 2'b00;

    // R11: write and receive arm in the same idle cycle
    @(negedge clk); rx_en = 1; wr_stb = 1; wr_byte = 8'h81;
    @(negedge clk); wr_stb = 0; rx_en = 0;
    chk("R11 transmit wins", {sdata_oe, sdata_out}, 2'b11);
    repeat (FRAME) @(negedge clk);
    chk("R11 tx completes", {tx_done, rx_done}, 2'b10);
    clear_flags();

    // idle with rx_en low: nothing moves
    begin
      bit quiet = 1;
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (sclk_out !== 1'b1) quiet = 0;
      end
      chk("R3 idle clock high", quiet, 1'b1);
    end

    finish_run();
  end

endmodule